// File: doc/BRIEF.md
# Double-Buffered Serial Control Register Bank

This block is the control front end of a multi-channel synthesizer. A four-wire serial port writes into a bank of staging (buffer) registers. A separate set of live (active) registers drives the datapath, and it only takes on the staged values when a transfer event occurs. Because of this, a host can reprogram several registers one at a time and make all of them take effect together.

A transfer is caused either by a rising edge on the commit request input or by any change of the 4-bit profile select input. Both inputs are resynchronised on a slow sync clock (the system clock divided down). This gives a fixed number of cycles from a trigger to the active registers, and the sync clock is brought out so that external logic can time its triggers against it. The serial port can read back the staging registers. An active-high hard reset returns every staging register and every active register to its default value.

Each serial transaction starts when the select line goes low. The master then sends an 8-bit instruction: bit 7 is the direction (1 = read) and the low address bits name a register. One register's worth of data follows, most significant bit first.

Top module: `dbuf_ctrl_bank`

## Requirements
- R1: While `hard_rst` is high, and after it is released, staging register i and active register i both hold the low REG_W bits of 0x13579BDF + i*0x1111. `active_profile` reads 0 and `ser_doe` is 0.
- R2: A write is an instruction with bit 7 = 0 and the register number in bits [ADDR_W-1:0], followed by REG_W data bits sent MSB first. Each bit is sampled on a rising `ser_clk` edge. The value lands in the staging register only, and the active registers do not change.
- R3: A read is an instruction with bit 7 = 1. The staging register's contents (not the active value) are driven MSB first on `ser_dout`. Each bit changes on a falling `ser_clk` edge, starting with the falling edge that follows the eighth rising edge. `ser_doe` is 1 from that point until the select line rises.
- R4: While `ser_sel_n` is high, `ser_clk` and `ser_din` activity changes no register, and `ser_doe` is 0.
- R5: A rising edge of `commit_req` copies every staging register into its active register in one step. A falling edge has no effect.
- R6: Any change of `prof_sel` performs the same copy, and `active_profile` takes the new profile value in the same cycle.
- R7: A trigger reaches the active registers at the third sync-clock tick after the input changes. With SYNC_DIV = 4, the active registers are unchanged 8 clocks after the input change and updated 12 clocks after it.
- R8: `sync_clk` has a period of SYNC_DIV system clocks and is high for half of them.
- R9: An instruction with any nonzero bit in [6:ADDR_W] names no register. A write with it changes nothing, and a read with it returns all zeros.
- R10: Serial clock edges after one register's data, within the same select period, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hard_rst | input | 1 | Active-high reset to default values |
| ser_sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial bit clock |
| ser_din | input | 1 | Serial data into the block |
| ser_dout | output | 1 | Serial readback data |
| ser_doe | output | 1 | Drive enable for ser_dout |
| commit_req | input | 1 | Rising edge requests a staging-to-active copy |
| prof_sel | input | PROF_W | Profile select; any change requests a copy |
| sync_clk | output | 1 | Divided clock used to sample the triggers |
| active_regs | output | NUM_REGS*REG_W | Active registers, register 0 in the low bits |
| active_profile | output | PROF_W | Profile value latched at the last transfer |

## Verification
The bench builds the block with ADDR_W = 2, REG_BYTES = 2 and SYNC_DIV = 4, which gives four 16-bit registers and a sync tick every four clocks. At this size every register can be written, read back and committed several times. The profile input can step through all sixteen of its values, and the transfer latency can be pinned to an exact window: still old after 8 clocks, updated by 12. The 4-bit profile width also brings the full change-detection space within reach, and the short divider makes the duty check of the sync clock cheap.

// File: rtl/dbuf_ctrl_pkg.sv
package dbuf_ctrl_pkg;
    // Reset value of register idx, before truncation to the register width.
    function automatic logic [31:0] default_word(input int idx);
        return 32'h1357_9BDF + 32'(idx) * 32'h0000_1111;
    endfunction
endpackage

// File: rtl/dbuf_sync2.sv
module dbuf_sync2 #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.s1 = din;
            st_d.s2 = st_q.s1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '{s1: RST_VAL, s2: RST_VAL};
        else     st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/dbuf_serial.sv
module dbuf_serial #(
    parameter int ADDR_W = 2,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              seln_s,
    input  logic              sdi_s,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [REG_W-1:0]  rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int LAST  = 8 + REG_W;
    localparam int CNT_W = $clog2(LAST + 1);

    typedef struct packed {
        logic             sclk_prev;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       instr;
        logic [REG_W-1:0] shreg;
        logic             done;
        logic             wr;
        logic             sdo;
        logic             oe;
    } ser_t;

    ser_t ser_d, ser_q;
    logic rise, fall;
    logic [7:0] instr_next;

    function automatic logic addr_ok(input logic [7:0] ins);
        return ((ins[6:0] >> ADDR_W) == 7'd0);
    endfunction

    assign instr_next = {ser_q.instr[6:0], sdi_s};
    assign rd_addr    = instr_next[ADDR_W-1:0];
    assign rise       = sclk_s & ~ser_q.sclk_prev;
    assign fall       = ~sclk_s & ser_q.sclk_prev;

    always_comb begin
        ser_d           = ser_q;
        ser_d.wr        = 1'b0;
        ser_d.sclk_prev = sclk_s;
        if (seln_s) begin
            ser_d.cnt  = '0;
            ser_d.done = 1'b0;
            ser_d.oe   = 1'b0;
            ser_d.sdo  = 1'b0;
        end else if (rise && !ser_q.done) begin
            ser_d.cnt = ser_q.cnt + 1'b1;
            if (ser_q.cnt < CNT_W'(8)) begin
                ser_d.instr = instr_next;
                if (ser_q.cnt == CNT_W'(7))
                    ser_d.shreg = (instr_next[7] && addr_ok(instr_next)) ? rd_data : '0;
            end else begin
                if (!ser_q.instr[7])
                    ser_d.shreg = {ser_q.shreg[REG_W-2:0], sdi_s};
                if (ser_q.cnt == CNT_W'(LAST - 1)) begin
                    ser_d.done = 1'b1;
                    ser_d.wr   = !ser_q.instr[7] && addr_ok(ser_q.instr);
                end
            end
        end else if (fall && ser_q.instr[7] &&
                     ser_q.cnt >= CNT_W'(8) && ser_q.cnt < CNT_W'(LAST)) begin
            ser_d.sdo   = ser_q.shreg[REG_W-1];
            ser_d.shreg = {ser_q.shreg[REG_W-2:0], 1'b0};
            ser_d.oe    = 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) ser_q <= '0;
        else     ser_q <= ser_d;
    end

    assign wr_en   = ser_q.wr;
    assign wr_addr = ser_q.instr[ADDR_W-1:0];
    assign wr_data = ser_q.shreg;
    assign sdo     = ser_q.sdo;
    assign sdo_oe  = ser_q.oe;
endmodule

// File: rtl/dbuf_trigger.sv
module dbuf_trigger #(
    parameter int PROF_W   = 4,
    parameter int SYNC_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_req,
    input  logic [PROF_W-1:0] prof_sel,
    output logic              sync_clk,
    output logic              xfer,
    output logic [PROF_W-1:0] prof_now
);
    localparam int CW = (SYNC_DIV > 1) ? $clog2(SYNC_DIV) : 1;
    localparam int TW = PROF_W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [TW-1:0] prev;
    } trg_t;

    trg_t trg_d, trg_q;
    logic tick;
    logic [TW-1:0] trig_s;

    assign tick = (trg_q.cnt == CW'(SYNC_DIV - 1));

    dbuf_sync2 #(.W(TW), .RST_VAL('0)) trig_sync_i (
        .clk  (clk),
        .rst  (rst),
        .en   (tick),
        .din  ({commit_req, prof_sel}),
        .dout (trig_s)
    );

    always_comb begin
        trg_d     = trg_q;
        trg_d.cnt = tick ? '0 : trg_q.cnt + 1'b1;
        if (tick) trg_d.prev = trig_s;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) trg_q <= '0;
        else     trg_q <= trg_d;
    end

    assign xfer = tick && ((trig_s[TW-1] && !trg_q.prev[TW-1]) ||
                           (trig_s[PROF_W-1:0] != trg_q.prev[PROF_W-1:0]));
    assign prof_now = trig_s[PROF_W-1:0];
    assign sync_clk = (trg_q.cnt >= CW'(SYNC_DIV / 2));
endmodule

// File: rtl/dbuf_ctrl_bank.sv
module dbuf_ctrl_bank #(
    parameter int ADDR_W    = 2,
    parameter int REG_BYTES = 2,
    parameter int PROF_W    = 4,
    parameter int SYNC_DIV  = 4,
    localparam int NUM_REGS = 1 << ADDR_W,
    localparam int REG_W    = 8 * REG_BYTES
) (
    input  logic                      clk,
    input  logic                      hard_rst,
    input  logic                      ser_sel_n,
    input  logic                      ser_clk,
    input  logic                      ser_din,
    output logic                      ser_dout,
    output logic                      ser_doe,
    input  logic                      commit_req,
    input  logic [PROF_W-1:0]         prof_sel,
    output logic                      sync_clk,
    output logic [NUM_REGS*REG_W-1:0] active_regs,
    output logic [PROF_W-1:0]         active_profile
);
    import dbuf_ctrl_pkg::*;

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] stage;
        logic [NUM_REGS-1:0][REG_W-1:0] live;
        logic [PROF_W-1:0]              prof;
    } bank_t;

    bank_t bank_d, bank_q, bank_rst;
    logic [2:0] ser_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [REG_W-1:0] rd_data, wr_data;
    logic wr_en, xfer_w;
    logic [PROF_W-1:0] prof_now;

    dbuf_sync2 #(.W(3), .RST_VAL(3'b010)) ser_sync_i (
        .clk  (clk),
        .rst  (hard_rst),
        .en   (1'b1),
        .din  ({ser_clk, ser_sel_n, ser_din}),
        .dout (ser_s)
    );

    dbuf_serial #(.ADDR_W(ADDR_W), .REG_W(REG_W)) serial_i (
        .clk     (clk),
        .rst     (hard_rst),
        .sclk_s  (ser_s[2]),
        .seln_s  (ser_s[1]),
        .sdi_s   (ser_s[0]),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo     (ser_dout),
        .sdo_oe  (ser_doe)
    );

    dbuf_trigger #(.PROF_W(PROF_W), .SYNC_DIV(SYNC_DIV)) trigger_i (
        .clk        (clk),
        .rst        (hard_rst),
        .commit_req (commit_req),
        .prof_sel   (prof_sel),
        .sync_clk   (sync_clk),
        .xfer       (xfer_w),
        .prof_now   (prof_now)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_rst
        assign bank_rst.stage[g] = REG_W'(default_word(g));
        assign bank_rst.live[g]  = REG_W'(default_word(g));
        assign active_regs[g*REG_W +: REG_W] = bank_q.live[g];
    end
    assign bank_rst.prof = '0;

    assign rd_data = bank_q.stage[rd_addr];

    always_comb begin
        bank_d = bank_q;
        if (wr_en) bank_d.stage[wr_addr] = wr_data;
        if (xfer_w) begin
            bank_d.live = bank_q.stage;
            bank_d.prof = prof_now;
        end
    end

    always_ff @(posedge clk or posedge hard_rst) begin
        if (hard_rst) bank_q <= bank_rst;
        else          bank_q <= bank_d;
    end

    assign active_profile = bank_q.prof;
endmodule

// File: rtl/dbuf_ctrl_bank_chk.sv
module dbuf_ctrl_bank_chk #(
    parameter int ACT_W  = 64,
    parameter int PROF_W = 4
) (
    input logic              clk,
    input logic              hard_rst,
    input logic              ser_sel_n,
    input logic              ser_doe,
    input logic              sync_clk,
    input logic [ACT_W-1:0]  active_regs,
    input logic [PROF_W-1:0] active_profile,
    input logic              xfer
);
    // R4
    oe_released_chk: assert property (@(posedge clk) disable iff (hard_rst)
        (ser_sel_n && $past(ser_sel_n) && $past(ser_sel_n, 2) && $past(ser_sel_n, 3))
        |-> !ser_doe);

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (hard_rst)
        !$past(xfer) |-> $stable(active_regs));

    // R6
    profile_hold_chk: assert property (@(posedge clk) disable iff (hard_rst)
        !$past(xfer) |-> $stable(active_profile));

    // R8
    sync_clk_duty_chk: assert property (@(posedge clk) disable iff (hard_rst)
        (sync_clk != $past(sync_clk)) |=> $stable(sync_clk));
endmodule

bind dbuf_ctrl_bank dbuf_ctrl_bank_chk #(
    .ACT_W  (NUM_REGS * REG_W),
    .PROF_W (PROF_W)
) chk_i (
    .clk            (clk),
    .hard_rst       (hard_rst),
    .ser_sel_n      (ser_sel_n),
    .ser_doe        (ser_doe),
    .sync_clk       (sync_clk),
    .active_regs    (active_regs),
    .active_profile (active_profile),
    .xfer           (xfer_w)
);

// File: tb/dbuf_ctrl_bank_tb.sv
module dbuf_ctrl_bank_tb_top;
    localparam int NR = 4;
    localparam int RW = 16;

    logic clk = 1'b0;
    logic hard_rst = 1'b1;
    logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
    logic ser_dout, ser_doe;
    logic commit_req = 1'b0;
    logic [3:0] prof_sel = 4'd0;
    logic sync_clk;
    logic [NR*RW-1:0] active_regs;
    logic [3:0] active_profile;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [RW-1:0] exp_stage [NR];
    logic [RW-1:0] exp_live  [NR];

    always #10 clk = ~clk;

    dbuf_ctrl_bank #(.ADDR_W(2), .REG_BYTES(2), .PROF_W(4), .SYNC_DIV(4)) dut_i (
        .clk(clk), .hard_rst(hard_rst), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_doe(ser_doe),
        .commit_req(commit_req), .prof_sel(prof_sel), .sync_clk(sync_clk),
        .active_regs(active_regs), .active_profile(active_profile)
    );

    function automatic logic [RW-1:0] dflt(input int i);
        logic [31:0] v;
        v = 32'h1357_9BDF + 32'(i) * 32'h1111;
        return v[RW-1:0];
    endfunction

    function automatic logic [RW-1:0] pat(input int i, input int k);
        return RW'(16'h2345 * (i + 1) + 16'h0F0F * k + 16'h8001 * (k & 1));
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Data is left-aligned in dat; nbits data bits follow the instruction.
    task automatic ser_txn(input logic [7:0] ins, input logic [31:0] dat, input int nbits,
                           output logic [RW-1:0] rd, output logic oe_seen);
        rd = '0;
        oe_seen = 1'b1;
        ser_sel_n = 1'b0;
        wait_clk(4);
        for (int b = 0; b < 8 + nbits; b++) begin
            ser_din = (b < 8) ? ins[7-b] : dat[31-(b-8)];
            wait_clk(4);
            if (b >= 8 && b < 8 + RW) begin
                rd = {rd[RW-2:0], ser_dout};
                oe_seen = oe_seen & ser_doe;
            end
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(4);
        ser_sel_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic wr_reg(input logic [7:0] ins, input logic [RW-1:0] v);
        logic [RW-1:0] dummy;
        logic o;
        ser_txn(ins, {v, 16'h0}, RW, dummy, o);
    endtask

    task automatic rd_reg(input logic [7:0] ins, output logic [RW-1:0] v);
        logic o;
        ser_txn(ins, 32'hFFFF_FFFF, RW, v, o);
        chk("R3 oe during read", 64'(o), 64'd1);
        chk("R3 oe released", 64'(ser_doe), 64'd0);
    endtask

    task automatic chk_live(input string req);
        for (int i = 0; i < NR; i++)
            chk(req, 64'(active_regs[i*RW +: RW]), 64'(exp_live[i]));
    endtask

    task automatic do_reset;
        hard_rst = 1'b1;
        wait_clk(3);
        for (int i = 0; i < NR; i++) begin
            exp_stage[i] = dflt(i);
            exp_live[i]  = dflt(i);
        end
        chk_live("R1 during reset");
        hard_rst = 1'b0;
        wait_clk(2);
        chk_live("R1 after reset");
        chk("R1 profile", 64'(active_profile), 64'd0);
        chk("R1 oe", 64'(ser_doe), 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [RW-1:0] rv;
        logic o;
        wait_clk(1);
        do_reset();
        for (int i = 0; i < NR; i++) begin
            rd_reg(8'h80 | 8'(i), rv);
            chk("R1 readback default", 64'(rv), 64'(dflt(i)));
        end

        // R8: sync clock period and duty
        begin
            int highs = 0, edges = 0;
            logic last;
            last = sync_clk;
            for (int c = 0; c < 16; c++) begin
                wait_clk(1);
                highs += int'(sync_clk);
                if (sync_clk != last) edges++;
                last = sync_clk;
            end
            chk("R8 high count", 64'(highs), 64'd8);
            chk("R8 edge count", 64'(edges), 64'd8);
        end

        // R2 R3 R5 R7: write, readback of staging, commit
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < NR; i++) begin
                wr_reg(8'(i), pat(i, k));
                exp_stage[i] = pat(i, k);
            end
            chk_live("R2 live unchanged by write");
            for (int i = 0; i < NR; i++) begin
                rd_reg(8'h80 | 8'(i), rv);
                chk("R3 readback staging", 64'(rv), 64'(exp_stage[i]));
            end
            commit_req = 1'b1;
            wait_clk(8);
            chk_live("R7 not yet at 8 clocks");
            wait_clk(4);
            for (int i = 0; i < NR; i++) exp_live[i] = exp_stage[i];
            chk_live("R5 commit copies all");
            wr_reg(8'd0, ~pat(0, k));
            exp_stage[0] = ~pat(0, k);
            commit_req = 1'b0;
            wait_clk(16);
            chk_live("R5 falling edge no copy");
        end

        // R6 R7: every profile value
        for (int p = 1; p < 16; p++) begin
            wr_reg(8'(p % NR), pat(p, 7));
            exp_stage[p % NR] = pat(p, 7);
            prof_sel = 4'(p);
            wait_clk(8);
            chk_live("R7 profile not yet");
            chk("R7 profile old", 64'(active_profile), 64'(p - 1));
            wait_clk(4);
            for (int i = 0; i < NR; i++) exp_live[i] = exp_stage[i];
            chk_live("R6 profile change copies");
            chk("R6 active profile", 64'(active_profile), 64'(p));
        end

        // R9: instruction with high address bits set
        wr_reg(8'h05, 16'hDEAD);
        rd_reg(8'h81, rv);
        chk("R9 write dropped", 64'(rv), 64'(exp_stage[1]));
        rd_reg(8'h85, rv);
        chk("R9 read zero", 64'(rv), 64'd0);

        // R10: extra clocks after one register
        ser_txn(8'h02, 32'hBEEF_1234, 32, rv, o);
        exp_stage[2] = 16'hBEEF;
        rd_reg(8'h82, rv);
        chk("R10 extra bits ignored", 64'(rv), 64'(exp_stage[2]));

        // R4: activity with select high
        ser_sel_n = 1'b1;
        for (int b = 0; b < 24; b++) begin
            ser_din = b[0];
            wait_clk(4);
            chk("R4 oe low", 64'(ser_doe), 64'd0);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        for (int i = 0; i < NR; i++) begin
            rd_reg(8'h80 | 8'(i), rv);
            chk("R4 staging unchanged", 64'(rv), 64'(exp_stage[i]));
        end

        // R1: reset in the middle of operation
        prof_sel = 4'd0;
        do_reset();
        rd_reg(8'h82, rv);
        chk("R1 staging default after reset", 64'(rv), 64'(dflt(2)));

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule